// File: doc/BRIEF.md
# Dot Matrix Refresh Scanner

This block drives the time-multiplexed refresh of a four-character 5x7 dot-matrix display. An oscillator tick, supplied as a clock-enable, advances a slot counter through 32 duty slots; every time the slot counter wraps, the scan moves to the next of the 7 dot rows, and after the last row it returns to the first. The current row is presented as a one-hot row select and as a binary index, and the slot index is exported so that a separate duty-control block can derive brightness and blanking from it.

For every digit the block presents the stored 7-bit character code and the current row index to an external combinational font port. The port returns a 5-bit column pattern per digit. A per-digit multiplexer either passes that pattern to the column outputs or, when the global cursor enable is high and the digit's cursor bit is set, replaces it with a solid block of all five columns. The block is lit only during the first half of each row period, so it appears at half the brightness of normal characters. Register storage, font contents and blanking decisions live outside the block.

Top module: `dm_scan_top`

## Requirements
- R1: While rst_ni is low and directly after reset, slot_o is 0, row_sel_o is 7'b0000001 and font_row_o is 0.
- R2: On a clock edge with tick_i high, slot_o advances by one; with tick_i low, slot_o and row_sel_o hold their values.
- R3: On a tick in slot 31, slot_o returns to 0 and the row advances by one; a tick in slot 31 of row 6 returns the row to 0. row_sel_o is one-hot with bit r set for row r.
- R4: font_row_o carries the current row index 0..6, and digit field d of font_code_o (bits 7d+6..7d) equals field d of char_codes_i.
- R5: With cursor_en_i low, column field d of cols_o (bits 5d+4..5d) equals field d of font_cols_i, whatever the cursor bits.
- R6: With cursor_en_i high and cursor_bits_i[d] set, column field d of cols_o is 5'b11111 in slots 0..15 and 5'b00000 in slots 16..31.
- R7: With cursor_en_i high and cursor_bits_i[d] clear, column field d of cols_o equals field d of font_cols_i.
- R8: slot_o is the index of the current duty slot, 0..31, counting ticks since the last row change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oscillator tick; scan advances one slot when high |
| char_codes_i | input | 28 | Four 7-bit character codes, digit d in bits 7d+6..7d |
| cursor_bits_i | input | 4 | Per-digit cursor bit |
| cursor_en_i | input | 1 | Global cursor enable |
| font_cols_i | input | 20 | Column patterns from the font port, digit d in bits 5d+4..5d |
| font_code_o | output | 28 | Character codes presented to the font port |
| font_row_o | output | 3 | Current row index presented to the font port |
| row_sel_o | output | 7 | One-hot row select |
| slot_o | output | 5 | Current duty slot index |
| cols_o | output | 20 | Column drive, digit d in bits 5d+4..5d |

## Verification
The assertions check on every cycle that the slot steps by exactly one per tick and freezes without one, that the row moves only on a slot wrap and wraps from the last row to the first, and that each digit's columns follow the font, the lit cursor or the dark cursor half as the cursor inputs and slot dictate. What only the bench's scenarios show is the absolute position of the scan against a tick count kept since reset across several full frames with irregular ticks, the pass-through of many changing character codes to the font port, and the mixing of cursor and character digits inside one row as the cursor enable toggles.

// File: rtl/dm_scan_pkg.sv
package dm_scan_pkg;
  localparam int unsigned DEF_DIGITS = 4;
  localparam int unsigned DEF_ROWS   = 7;
  localparam int unsigned DEF_COLS   = 5;
  localparam int unsigned DEF_SLOTS  = 32;
  localparam int unsigned DEF_CODE_W = 7;

  typedef enum logic [1:0] {
    SRC_FONT      = 2'd0,
    SRC_CURSOR_ON = 2'd1,
    SRC_CURSOR_OFF= 2'd2
  } col_src_e;
endpackage

// File: rtl/dm_scan_timer.sv
module dm_scan_timer #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned ROWS  = 7,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned ROW_W  = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [ROWS-1:0]   row_sel_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [ROW_W-1:0]  row_q;
  logic              slot_wrap;

  assign slot_wrap = tick_i && (slot_q == LAST_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else if (tick_i) begin
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
    end else if (slot_wrap) begin
      row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
    assign row_sel_o[r] = (row_q == ROW_W'(r));
  end

  assign slot_o = slot_q;
  assign row_o  = row_q;

  // R2
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && slot_q != LAST_SLOT) |=> slot_q == $past(slot_q) + 1'b1);
  // R2
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(slot_q) && $stable(row_q)));
  // R3
  row_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && slot_q == LAST_SLOT && row_q != LAST_ROW) |=>
      (slot_q == '0 && row_q == $past(row_q) + 1'b1));
  // R3
  row_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && slot_q == LAST_SLOT && row_q == LAST_ROW) |=> row_q == '0);
  // R3
  row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= LAST_ROW);
  // R3
  row_sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(row_sel_o));
endmodule

// File: rtl/dm_scan_cell.sv
module dm_scan_cell
  import dm_scan_pkg::*;
#(
  parameter int unsigned COLS  = 5,
  parameter int unsigned SLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned HALF   = SLOTS / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cursor_en_i,
  input  logic              cursor_bit_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [COLS-1:0]   font_cols_i,
  output logic [COLS-1:0]   cols_o
);
  col_src_e src;

  always_comb begin
    if (!(cursor_en_i && cursor_bit_i)) begin
      src = SRC_FONT;
    end else if (slot_i < SLOT_W'(HALF)) begin
      src = SRC_CURSOR_ON;
    end else begin
      src = SRC_CURSOR_OFF;
    end
  end

  always_comb begin
    unique case (src)
      SRC_CURSOR_ON:  cols_o = '1;
      SRC_CURSOR_OFF: cols_o = '0;
      default:        cols_o = font_cols_i;
    endcase
  end

  // R5
  font_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cursor_en_i |-> cols_o == font_cols_i);
  // R6
  cursor_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cursor_en_i && cursor_bit_i && slot_i < SLOT_W'(HALF)) |-> (&cols_o));
  // R6
  cursor_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cursor_en_i && cursor_bit_i && slot_i >= SLOT_W'(HALF)) |-> cols_o == '0);
  // R7
  no_cursor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cursor_en_i && !cursor_bit_i) |-> cols_o == font_cols_i);
endmodule

// File: rtl/dm_scan_top.sv
module dm_scan_top
  import dm_scan_pkg::*;
#(
  parameter int unsigned DIGITS = DEF_DIGITS,
  parameter int unsigned ROWS   = DEF_ROWS,
  parameter int unsigned COLS   = DEF_COLS,
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned CODE_W = DEF_CODE_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned ROW_W  = $clog2(ROWS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [DIGITS*CODE_W-1:0] char_codes_i,
  input  logic [DIGITS-1:0]        cursor_bits_i,
  input  logic                     cursor_en_i,
  input  logic [DIGITS*COLS-1:0]   font_cols_i,
  output logic [DIGITS*CODE_W-1:0] font_code_o,
  output logic [ROW_W-1:0]         font_row_o,
  output logic [ROWS-1:0]          row_sel_o,
  output logic [SLOT_W-1:0]        slot_o,
  output logic [DIGITS*COLS-1:0]   cols_o
);
  logic [SLOT_W-1:0] slot;
  logic [ROW_W-1:0]  row;

  dm_scan_timer #(.SLOTS(SLOTS), .ROWS(ROWS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .slot_o    (slot),
    .row_o     (row),
    .row_sel_o (row_sel_o)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign font_code_o[d*CODE_W +: CODE_W] = char_codes_i[d*CODE_W +: CODE_W];

    dm_scan_cell #(.COLS(COLS), .SLOTS(SLOTS)) u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cursor_en_i  (cursor_en_i),
      .cursor_bit_i (cursor_bits_i[d]),
      .slot_i       (slot),
      .font_cols_i  (font_cols_i[d*COLS +: COLS]),
      .cols_o       (cols_o[d*COLS +: COLS])
    );
  end

  assign font_row_o = row;
  assign slot_o     = slot;

  // R4
  font_row_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_sel_o[font_row_o]);
  // R8
  slot_wrap_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o != '0) |=> (!tick_i && $past(tick_i)) || $stable(font_row_o) || slot_o == '0);
endmodule

// File: tb/dm_scan_top_tb.sv
module dm_scan_top_tb;
  localparam int DIGITS = 4, ROWS = 7, COLS = 5, SLOTS = 32, CODE_W = 7;
  localparam int CYCLES = 2400;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     tick = 1'b0;
  logic [DIGITS*CODE_W-1:0] codes = '0;
  logic [DIGITS-1:0]        cbits = '0;
  logic                     cen = 1'b0;
  logic [DIGITS*COLS-1:0]   fcols;
  logic [DIGITS*CODE_W-1:0] fcode;
  logic [2:0]               frow;
  logic [ROWS-1:0]          rsel;
  logic [4:0]               slot;
  logic [DIGITS*COLS-1:0]   cols;

  int vectors = 0;
  int misses  = 0;
  int n_ticks = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dm_scan_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .char_codes_i(codes),
    .cursor_bits_i(cbits), .cursor_en_i(cen), .font_cols_i(fcols),
    .font_code_o(fcode), .font_row_o(frow), .row_sel_o(rsel),
    .slot_o(slot), .cols_o(cols)
  );

  function automatic logic [4:0] glyph(input logic [6:0] code, input int row);
    return 5'((int'(code) * 3 + row * 11 + (int'(code) >> 4)) & 31);
  endfunction

  always_comb begin
    for (int d = 0; d < DIGITS; d++)
      fcols[d*COLS +: COLS] = glyph(fcode[d*CODE_W +: CODE_W], int'(frow));
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h (ticks=%0d)", req, act, exp, n_ticks);
    end
  endtask

  task automatic check_all();
    int es, er;
    es = n_ticks % SLOTS;
    er = (n_ticks / SLOTS) % ROWS;
    check("R8 slot", int'(slot), es);
    check("R3 row_sel", int'(rsel), 1 << er);
    check("R4 font_row", int'(frow), er);
    for (int d = 0; d < DIGITS; d++) begin
      int code, expc;
      code = int'(codes[d*CODE_W +: CODE_W]);
      check("R4 font_code", int'(fcode[d*CODE_W +: CODE_W]), code);
      if (cen && cbits[d]) begin
        expc = (es < SLOTS / 2) ? 31 : 0;
        check("R6 cursor cols", int'(cols[d*COLS +: COLS]), expc);
      end else if (cen) begin
        expc = int'(glyph(7'(code), er));
        check("R7 font cols under cursor enable", int'(cols[d*COLS +: COLS]), expc);
      end else begin
        expc = int'(glyph(7'(code), er));
        check("R5 font cols", int'(cols[d*COLS +: COLS]), expc);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    check("R1 slot in reset", int'(slot), 0);
    check("R1 row_sel in reset", int'(rsel), 1);
    check("R1 font_row in reset", int'(frow), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(negedge clk);
      check_all();
      // R2: irregular ticks so held slots are exercised
      tick  = !((cyc % 5) == 3 || (cyc % 17) == 0);
      cen   = ((cyc / 150) % 2) == 1;
      cbits = 4'((cyc / 37) % 16);
      for (int d = 0; d < DIGITS; d++)
        codes[d*CODE_W +: CODE_W] = 7'((cyc * 7 + d * 29 + (cyc >> 3)) % 128);
      if (tick) n_ticks++;
    end
    // R1: reset mid-frame returns to slot 0, row 0
    @(negedge clk);
    tick = 1'b0;
    rst_n = 1'b0;
    n_ticks = 0;
    @(negedge clk);
    check("R1 slot after reset", int'(slot), 0);
    check("R1 row_sel after reset", int'(rsel), 1);
    rst_n = 1'b1;
    tick = 1'b1;
    for (int cyc = 0; cyc < SLOTS * ROWS + 40; cyc++) begin
      n_ticks++;
      @(negedge clk);
      check_all();
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule